// File: doc/BRIEF.md
# Misaligned Operand Splitter

This block sits between a load/store pipeline and a 32-bit external bus. It accepts one operand request at a time. Each request carries an address, an operand size (byte, word or longword), a direction, an instruction-fetch flag, a cache-inhibit flag and write data. An operand that is naturally aligned goes out as a single bus cycle. A cache-inhibited operand that straddles its natural alignment is broken into a short run of aligned bus cycles. Each piece is chosen from the current byte offset and the bytes still owed, so one operand can become a mix of byte and word cycles.

Every bus cycle carries a two-bit size code and a full byte address, and stays on the bus until the slave acknowledges it. Write bytes are steered onto big-endian byte lanes. Read bytes are collected from the lanes and packed into a right-justified operand, which is delivered with a one-cycle completion pulse. Two kinds of request never reach the bus. An instruction fetch at an odd address raises an address-error pulse. A misaligned cacheable operand raises a bypass pulse and is left to the cache path.

Top module: `opnd_splitter`

## Requirements
- R1: Each bus cycle drives `bus_size` as 01 for a byte, 10 for a word and 00 for a longword, and `bus_addr` as the full byte address of the piece, so that its two low bits are the byte offset. The same codes are used on `req_size`, where code 11 is handled as a longword.
- R2: Each piece takes the largest size that is naturally aligned at the current offset, is no larger than the bytes still owed, and stays inside the current longword.
- R3: A longword at byte offset 1 takes three bus cycles, in this order: a byte at offset 1, a word at offset 2, then a byte at offset 0 of the next longword.
- R4: A misaligned word takes exactly two bus cycles.
- R5: Lanes are big-endian: byte offset 0 is bits 31:24 and offset 3 is bits 7:0. Operand bytes go out most significant first on the write lanes they address. A read operand appears right-justified and zero-extended on `op_rdata`.
- R6: A bus cycle holds `bus_valid`, `bus_addr`, `bus_size` and `bus_wdata` unchanged until `bus_ack` is sampled high. There is no internal timeout.
- R7: `op_done` is a one-cycle pulse in the cycle after the final acknowledge. For a read, `op_rdata` holds the operand in that cycle.
- R8: An aligned operand, and any byte operand, uses one bus cycle. That cycle starts in the cycle after acceptance, and with an immediate acknowledge `op_done` follows two cycles after acceptance.
- R9: An instruction fetch with address bit 0 set starts no bus cycle and pulses `addr_err` in the cycle after acceptance. This check takes precedence over R10.
- R10: A misaligned request with `req_cinh` low starts no bus cycle and pulses `bypass` in the cycle after acceptance.
- R11: `req_busy` is high while a bus sequence runs. A request presented while busy is ignored and causes no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | AW | Operand byte address |
| req_size | input | 2 | Operand size code |
| req_write | input | 1 | 1 = store, 0 = load |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_cinh | input | 1 | Operand is cache-inhibited |
| req_wdata | input | DW | Store data, right-justified |
| req_busy | output | 1 | Sequence running, requests refused |
| addr_err | output | 1 | Misaligned fetch pulse |
| bypass | output | 1 | Misaligned cacheable pulse |
| op_done | output | 1 | Operand complete pulse |
| op_rdata | output | DW | Loaded operand, right-justified |
| bus_valid | output | 1 | Bus cycle active |
| bus_addr | output | AW | Bus cycle byte address |
| bus_size | output | 2 | Bus cycle size code |
| bus_write | output | 1 | Bus cycle direction |
| bus_wdata | output | DW | Bus write lanes |
| bus_ack | input | 1 | Transfer acknowledge |
| bus_rdata | input | DW | Bus read lanes |

## Verification
Two events can fall in the same cycle. The slave's acknowledge of the last piece can coincide with a fresh request. Separately, the completion pulse can coincide with the acceptance of the next request. The bench raises a request in the exact cycle it acknowledges the third piece of a three-piece longword, and confirms that `req_busy` was high, that the completion arrives on time and that no bus cycle follows. It then starts each new operation in the very cycle the previous completion is observed. Each such operation must show its normal piece list and completion delay, which proves the request was taken while the pulse was high.

// File: rtl/opnd_split_pkg.sv
`timescale 1ns/1ps
package opnd_split_pkg;

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } bsize_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } st_e;

    // operand byte count from a size code (reserved code acts as longword)
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_WORD: size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/split_piece_sel.sv
`timescale 1ns/1ps
module split_piece_sel
    import opnd_split_pkg::*;
(
    input  logic [1:0] off,
    input  logic [2:0] rem,
    output logic [1:0] pc_size,
    output logic [2:0] pc_nb
);
    // largest naturally aligned piece that fits the remainder and the longword
    always_comb begin
        if (off == 2'd0 && rem >= 3'd4) begin
            pc_size = SZ_LONG;
            pc_nb   = 3'd4;
        end else if (!off[0] && rem >= 3'd2) begin
            pc_size = SZ_WORD;
            pc_nb   = 3'd2;
        end else begin
            pc_size = SZ_BYTE;
            pc_nb   = 3'd1;
        end
    end
endmodule

// File: rtl/split_wr_place.sv
`timescale 1ns/1ps
module split_wr_place #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] opnd_l,   // operand left-justified, byte 0 in top lane
    input  logic [2:0]    used,     // operand bytes already sent
    input  logic [1:0]    off,      // lane of the current piece
    output logic [DW-1:0] lanes
);
    logic [DW-1:0] rest;

    always_comb begin
        rest  = opnd_l << (8 * used);
        lanes = rest >> (8 * off);
    end
endmodule

// File: rtl/split_rd_merge.sv
`timescale 1ns/1ps
module split_rd_merge #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] rdata,
    input  logic [1:0]    off,
    input  logic [2:0]    used,
    input  logic [2:0]    nbytes,
    output logic [DW-1:0] merged
);
    localparam int LANES = DW / 8;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic       in_rng;
        logic [2:0] src;
        always_comb begin
            in_rng = (3'(k) >= used) && (3'(k) < (used + nbytes));
            src    = 3'(k) - used + {1'b0, off};
            if (in_rng)
                merged[DW-1-8*k -: 8] = rdata[DW-1-8*int'(src[1:0]) -: 8];
            else
                merged[DW-1-8*k -: 8] = acc[DW-1-8*k -: 8];
        end
    end
endmodule

// File: rtl/opnd_splitter.sv
`timescale 1ns/1ps
module opnd_splitter
    import opnd_split_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic          req_write,
    input  logic          req_fetch,
    input  logic          req_cinh,
    input  logic [DW-1:0] req_wdata,
    output logic          req_busy,
    output logic          addr_err,
    output logic          bypass,
    output logic          op_done,
    output logic [DW-1:0] op_rdata,
    output logic          bus_valid,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic          bus_write,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata
);
    localparam int LANES = DW / 8;

    typedef struct packed {
        st_e           st;
        logic [AW-1:0] addr;
        logic [2:0]    total;
        logic [2:0]    used;
        logic          wr;
        logic [DW-1:0] opnd;
        logic [DW-1:0] acc;
        logic          done;
        logic          err;
        logic          byp;
        logic [DW-1:0] rdata;
    } state_t;

    state_t q, d;

    logic [2:0]    rem;
    logic [1:0]    pc_size;
    logic [2:0]    pc_nb;
    logic [DW-1:0] merged;
    logic [DW-1:0] placed;
    logic [2:0]    in_nb;
    logic          in_misal;
    logic [2:0]    used_nx;

    assign rem = q.total - q.used;

    split_piece_sel u_sel (
        .off     (q.addr[1:0]),
        .rem     (rem),
        .pc_size (pc_size),
        .pc_nb   (pc_nb)
    );

    split_wr_place #(.DW(DW)) u_place (
        .opnd_l (q.opnd),
        .used   (q.used),
        .off    (q.addr[1:0]),
        .lanes  (placed)
    );

    split_rd_merge #(.DW(DW)) u_merge (
        .acc    (q.acc),
        .rdata  (bus_rdata),
        .off    (q.addr[1:0]),
        .used   (q.used),
        .nbytes (pc_nb),
        .merged (merged)
    );

    always_comb begin
        in_nb    = size_bytes(req_size);
        in_misal = ((in_nb != 3'd1) && req_addr[0]) ||
                   ((in_nb == 3'd4) && req_addr[1]);
        used_nx  = q.used + pc_nb;

        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        d.byp  = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_fetch && req_addr[0]) begin
                        d.err = 1'b1;
                    end else if (in_misal && !req_cinh) begin
                        d.byp = 1'b1;
                    end else begin
                        d.st    = ST_RUN;
                        d.addr  = req_addr;
                        d.total = in_nb;
                        d.used  = 3'd0;
                        d.wr    = req_write;
                        d.opnd  = req_wdata << (8 * (LANES - int'(in_nb)));
                        d.acc   = '0;
                    end
                end
            end
            ST_RUN: begin
                if (bus_ack) begin
                    d.acc  = merged;
                    d.used = used_nx;
                    d.addr = q.addr + AW'(pc_nb);
                    if (used_nx == q.total) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        if (!q.wr)
                            d.rdata = merged >> (8 * (LANES - int'(q.total)));
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_busy  = (q.st == ST_RUN);
    assign bus_valid = (q.st == ST_RUN);
    assign bus_addr  = q.addr;
    assign bus_size  = pc_size;
    assign bus_write = q.wr;
    assign bus_wdata = placed;
    assign op_done   = q.done;
    assign addr_err  = q.err;
    assign bypass    = q.byp;
    assign op_rdata  = q.rdata;

endmodule

// File: rtl/opnd_splitter_chk.sv
`timescale 1ns/1ps
module opnd_splitter_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_valid,
    input logic          bus_ack,
    input logic [AW-1:0] bus_addr,
    input logic [1:0]    bus_size,
    input logic [DW-1:0] bus_wdata,
    input logic          op_done,
    input logic          addr_err,
    input logic          bypass
);
    AST_SIZE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> bus_size != 2'b11); // R1

    AST_PIECE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> ((bus_size != 2'b00) || (bus_addr[1:0] == 2'b00)) &&
                      ((bus_size != 2'b10) || !bus_addr[0])); // R2

    AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ack) |=> bus_valid && $stable(bus_addr) &&
                                    $stable(bus_size) && $stable(bus_wdata)); // R6

    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> $past(bus_valid && bus_ack)); // R7

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_done, addr_err, bypass})); // R7

    AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> !bus_valid); // R9

    AST_BYP_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> !bus_valid); // R10
endmodule

bind opnd_splitter opnd_splitter_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/opnd_splitter_bench.sv
`timescale 1ns/1ps
module opnd_splitter_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic        req_write;
    logic        req_fetch;
    logic        req_cinh;
    logic [31:0] req_wdata;
    logic        req_busy;
    logic        addr_err;
    logic        bypass;
    logic        op_done;
    logic [31:0] op_rdata;
    logic        bus_valid;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic        bus_write;
    logic [31:0] bus_wdata;
    logic        bus_ack;
    logic [31:0] bus_rdata;

    always #2.5 clk = ~clk;

    opnd_splitter u_opnd_splitter (.*);

    logic [7:0]  mem [0:15];
    int          total = 0;
    int          bad = 0;
    int          npc;
    logic [1:0]  psz [0:3];
    logic [31:0] pad [0:3];
    bit          saw_done, saw_err, saw_byp, busy_at_inj;
    int          done_at, err_at, byp_at;
    logic [31:0] rd_got;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic int nb_of(input logic [1:0] c);
        return (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : 4;
    endfunction

    // issue one request at the current negedge and act as the slave
    task automatic do_op(input logic [31:0] a, input logic [1:0] sz,
                         input bit wr, input bit fetch, input bit cinh,
                         input logic [31:0] wd, input int waits, input int inj_at);
        int waited;
        waited = 0;
        npc = 0; saw_done = 0; saw_err = 0; saw_byp = 0; busy_at_inj = 0;
        done_at = -1; err_at = -1; byp_at = -1;
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
        req_fetch = fetch; req_cinh = cinh; req_wdata = wd;
        @(negedge clk);
        for (int cyc = 1; cyc < 60; cyc++) begin
            bus_ack = 1'b0;
            if (inj_at == cyc) begin
                busy_at_inj = req_busy;
                req_valid = 1'b1; req_addr = 32'h0000_000C; req_size = 2'b01;
                req_fetch = 1'b0; req_cinh = 1'b1; req_write = 1'b0;
            end else begin
                req_valid = 1'b0;
            end
            if (addr_err) begin saw_err = 1; err_at = cyc; end
            if (bypass)   begin saw_byp = 1; byp_at = cyc; end
            if (op_done) begin
                saw_done = 1; done_at = cyc; rd_got = op_rdata;
                break;
            end
            if (bus_valid) begin
                if (waited == 0 && npc < 4) begin
                    psz[npc] = bus_size; pad[npc] = bus_addr;
                end
                for (int l = 0; l < 4; l++)
                    bus_rdata[31-8*l -: 8] = mem[{bus_addr[3:2], 2'(l)}];
                if (waited == waits) begin
                    bus_ack = 1'b1;
                    if (bus_write)
                        for (int l = 0; l < nb_of(bus_size); l++)
                            mem[{bus_addr[3:2], 2'(int'(bus_addr[1:0]) + l)}] =
                                bus_wdata[31-8*(int'(bus_addr[1:0]) + l) -: 8];
                    npc++;
                    waited = 0;
                end else begin
                    waited++;
                end
            end else if (cyc >= 3 && npc == 0) begin
                break;
            end
            @(negedge clk);
        end
        bus_ack = 1'b0;
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11", "busy after reset", 32'(req_busy), 0);
        chk("R6", "bus_valid after reset", 32'(bus_valid), 0);
        chk("R7", "op_done after reset", 32'(op_done), 0);
        chk("R9", "addr_err after reset", 32'(addr_err), 0);
    endtask

    task automatic t_long_off1;
        do_op(32'h1, 2'b00, 0, 0, 1, 0, 0, 0);
        chk("R3", "piece count", 32'(npc), 3);
        chk("R3", "piece0 size", 32'(psz[0]), 32'(2'b01));
        chk("R3", "piece0 addr", pad[0], 32'h1);
        chk("R3", "piece1 size", 32'(psz[1]), 32'(2'b10));
        chk("R3", "piece1 addr", pad[1], 32'h2);
        chk("R3", "piece2 size", 32'(psz[2]), 32'(2'b01));
        chk("R3", "piece2 addr", pad[2], 32'h4);
        chk("R5", "long off1 data", rd_got, 32'h11121314);
        chk("R7", "done delay", 32'(done_at), 4);
        @(negedge clk);
        chk("R7", "done one cycle", 32'(op_done), 0);
    endtask

    task automatic t_words;
        do_op(32'h3, 2'b10, 0, 0, 1, 0, 0, 0);
        chk("R4", "word off3 count", 32'(npc), 2);
        chk("R2", "word off3 p1 addr", pad[1], 32'h4);
        chk("R5", "word off3 data", rd_got, 32'h00001314);
        do_op(32'h1, 2'b10, 0, 0, 1, 0, 0, 0);
        chk("R4", "word off1 count", 32'(npc), 2);
        chk("R2", "word off1 p1 size", 32'(psz[1]), 32'(2'b01));
        chk("R5", "word off1 data", rd_got, 32'h00001112);
    endtask

    task automatic t_aligned;
        do_op(32'h8, 2'b00, 0, 0, 1, 0, 0, 0);
        chk("R8", "aligned count", 32'(npc), 1);
        chk("R8", "aligned done delay", 32'(done_at), 2);
        chk("R5", "aligned data", rd_got, 32'h18191a1b);
        do_op(32'h5, 2'b01, 0, 0, 1, 0, 0, 0);
        chk("R8", "byte count", 32'(npc), 1);
        chk("R1", "byte size code", 32'(psz[0]), 32'(2'b01));
        chk("R5", "byte data", rd_got, 32'h00000015);
        do_op(32'h0, 2'b11, 0, 0, 1, 0, 0, 0);
        chk("R1", "code 11 as long", 32'(psz[0]), 32'(2'b00));
        chk("R1", "code 11 data", rd_got, 32'h10111213);
    endtask

    task automatic t_waits;
        do_op(32'hA, 2'b00, 0, 0, 1, 0, 2, 0);
        chk("R6", "stalled count", 32'(npc), 2);
        chk("R2", "stalled p0 size", 32'(psz[0]), 32'(2'b10));
        chk("R2", "stalled p1 addr", pad[1], 32'hC);
        chk("R6", "stalled done delay", 32'(done_at), 7);
        chk("R6", "stalled data", rd_got, 32'h1a1b1c1d);
    endtask

    task automatic t_fetch;
        do_op(32'h5, 2'b10, 0, 1, 1, 0, 0, 0);
        chk("R9", "odd fetch no bus", 32'(npc), 0);
        chk("R9", "odd fetch err pulse", 32'(err_at), 1);
        chk("R9", "odd fetch no done", 32'(saw_done), 0);
        do_op(32'h2, 2'b00, 0, 1, 1, 0, 0, 0);
        chk("R9", "even fetch no err", 32'(saw_err), 0);
        chk("R2", "even fetch count", 32'(npc), 2);
        chk("R5", "even fetch data", rd_got, 32'h12131415);
    endtask

    task automatic t_cacheable;
        do_op(32'h1, 2'b00, 0, 0, 0, 0, 0, 0);
        chk("R10", "bypass no bus", 32'(npc), 0);
        chk("R10", "bypass pulse", 32'(byp_at), 1);
        do_op(32'h4, 2'b10, 0, 0, 0, 0, 0, 0);
        chk("R10", "aligned cacheable no bypass", 32'(saw_byp), 0);
        chk("R8", "aligned cacheable count", 32'(npc), 1);
        chk("R5", "aligned cacheable data", rd_got, 32'h00001415);
    endtask

    task automatic t_busy;
        // request lands in the same cycle as the last acknowledge
        do_op(32'h1, 2'b00, 0, 0, 1, 0, 0, 3);
        chk("R11", "busy at last ack", 32'(busy_at_inj), 1);
        chk("R11", "sequence intact", 32'(npc), 3);
        chk("R7", "done delay with clash", 32'(done_at), 4);
        chk("R11", "no bus after done", 32'(bus_valid), 0);
        @(negedge clk);
        chk("R11", "refused request silent", 32'(bus_valid), 0);
    endtask

    task automatic t_write;
        do_op(32'h3, 2'b00, 1, 0, 1, 32'hA1B2C3D4, 1, 0);
        chk("R2", "write count", 32'(npc), 3);
        chk("R2", "write p1 size", 32'(psz[1]), 32'(2'b10));
        chk("R2", "write p2 addr", pad[2], 32'h6);
        chk("R5", "write lanes", {mem[3], mem[4], mem[5], mem[6]}, 32'hA1B2C3D4);
        chk("R5", "write neighbours", {mem[2], mem[7]}, 32'h1217);
        do_op(32'h7, 2'b01, 1, 0, 1, 32'h0000005A, 0, 0);
        chk("R5", "byte write lane 3", 32'(mem[7]), 32'h5A);
        chk("R5", "byte write neighbour", 32'(mem[6]), 32'hD4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'h10 + 8'(i);
        rst_n = 1'b0; req_valid = 0; req_addr = 0; req_size = 0; req_write = 0;
        req_fetch = 0; req_cinh = 0; req_wdata = 0; bus_ack = 0; bus_rdata = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_long_off1();
        t_words();
        t_aligned();
        t_waits();
        t_fetch();
        t_cacheable();
        t_busy();
        t_write();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule